// File: doc/BRIEF.md
# Packed Half-Word Register Bridge

This block turns single 16-bit register requests into accesses on a 32-bit word-addressed memory bus. Each request names a lane, a page, a register and a direction, and carries 16-bit data for writes. Two neighbouring 16-bit registers share one 32-bit word, so a read picks one half of the word, and a write reads the word, swaps in one half and writes the whole word back.

The word address is computed from lane, page and register. The placement depends on the lane type: fast lanes 8, 9, 12 and 13, and slow lanes for all the rest. Several lane/page pairs are not backed by storage. These holes are answered without touching the bus. A request with a lane or page out of range is answered with an error flag. One request is in flight at a time. `req_ready` is low from acceptance until the one-cycle `done` pulse.

The controller is a single enumerated state machine with these states:
- IDLE: waits for a request.
- LOOKUP: classifies the request as error, hole or mapped.
- RD_ISSUE: drives the bus read.
- RD_WAIT: captures the read word.
- WR_ISSUE: drives the merged write.
- RESP: pulses `done`.

Its transitions are:
- IDLE→LOOKUP on accept.
- LOOKUP→RESP for errors and holes.
- LOOKUP→RD_ISSUE for mapped requests.
- RD_ISSUE→RD_WAIT always.
- RD_WAIT→WR_ISSUE for writes.
- RD_WAIT→RESP for reads.
- WR_ISSUE→RESP always.
- RESP→IDLE always.

Top module: `lane_reg_bridge`

## Requirements
- R1: Out of reset `req_ready` is 1, `done` is 0 and `mem_en` is 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` then stays low until `done` has been high for exactly one cycle. Only one request is served per acceptance.
- R3: For pages 0 to 3 the byte offset is ((lane with bit 0 cleared)·512) + ((reg with bit 0 cleared)·2) + page·64 + (lane bit 0)·256. `mem_addr` carries that byte offset divided by 4.
- R4: For pages 4 to 7 the offset is the same base plus 256 on lanes 8 and 12 only. Pages 4 to 7 of every other lane are holes.
- R5: Pages 8 and 9 map on slow lanes (0–7, 10, 11) with base + 256 + (lane bit 0)·128. Pages 10 and 11 map on fast lanes (8, 9, 12, 13) with base + 128 + (lane bit 0)·128. Any other pairing of these pages with a lane is a hole.
- R6: A read of a mapped register returns word bits 15:0 for an even register number and bits 31:16 for an odd one, using one bus read and no bus write.
- R7: A write to a mapped register first reads the word, then writes the same address with its own half replaced by the new data and the other half unchanged.
- R8: A hole answers reads with data 0 and error 0, drops writes, and issues no bus cycle.
- R9: A lane of 14 or more, or a page of 12 or more, gives `rsp_error` = 1 and `rsp_rdata` = 0, with no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lane | input | 4 | Lane number |
| req_page | input | 4 | Page number |
| req_reg | input | 5 | Register number within the page |
| req_wdata | input | 16 | Write value |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result, valid with `done` |
| rsp_error | output | 1 | Out-of-range request, valid with `done` |
| mem_en | output | 1 | Bus cycle strobe |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr | output | 11 | Word address (byte offset / 4) |
| mem_wdata | output | 32 | Word to write |
| mem_rdata | input | 32 | Read word, valid the cycle after a read strobe |

## Verification
The hardest case to reach from the ports is a write that must keep a neighbour half which was itself written earlier through the bridge. Checking against the preloaded image alone would not catch a merge that takes the neighbour from the wrong source. The stimulus therefore writes an even register, then the odd register of the same word. It reads both back and inspects the word in the bench memory. It also writes through a fast-lane page that shares its word layout with slow-lane pages, to show the merge follows the computed address and not the lane type.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_RD_ISSUE,
        ST_RD_WAIT,
        ST_WR_ISSUE,
        ST_RESP
    } lrb_state_e;

endpackage

// File: rtl/lrb_addr_map.sv
module lrb_addr_map #(
    parameter int LANE_W    = 4,
    parameter int PAGE_W    = 4,
    parameter int REG_W     = 5,
    parameter int ADDR_W    = 11,
    parameter int NUM_LANES = 14,
    parameter int NUM_PAGES = 12,
    parameter logic [(1<<LANE_W)-1:0] FAST_LANES = 'h3300,
    parameter logic [(1<<LANE_W)-1:0] WIDE_PAGE_LANES = 'h1100
) (
    input  logic [LANE_W-1:0] lane,
    input  logic [PAGE_W-1:0] page,
    input  logic [REG_W-1:0]  reg_idx,
    output logic              in_range,
    output logic              hole,
    output logic [ADDR_W-1:0] word_addr
);
    localparam int BYTE_W = ADDR_W + 2;

    logic [BYTE_W-1:0] base_off;
    logic [BYTE_W-1:0] byte_off;
    logic              lane_odd;
    logic              lane_fast;

    always_comb begin
        lane_odd  = lane[0];
        lane_fast = FAST_LANES[lane];
        in_range  = (int'(lane) < NUM_LANES) && (int'(page) < NUM_PAGES);
        base_off  = (BYTE_W'({lane[LANE_W-1:1], 1'b0}) << 9)
                  + (BYTE_W'({reg_idx[REG_W-1:1], 1'b0}) << 1)
                  + (BYTE_W'(page) << 6);
        hole      = 1'b0;
        byte_off  = base_off;
        if (page < PAGE_W'(4)) begin
            byte_off = base_off + (BYTE_W'(lane_odd) << 8);
        end else if (page < PAGE_W'(8)) begin
            if (WIDE_PAGE_LANES[lane]) byte_off = base_off + BYTE_W'(256);
            else                        hole     = 1'b1;
        end else if (page < PAGE_W'(10)) begin
            if (!lane_fast) byte_off = base_off + BYTE_W'(256) + (BYTE_W'(lane_odd) << 7);
            else            hole     = 1'b1;
        end else begin
            if (lane_fast) byte_off = base_off + BYTE_W'(128) + (BYTE_W'(lane_odd) << 7);
            else           hole     = 1'b1;
        end
        word_addr = byte_off[BYTE_W-1:2];
    end

endmodule

// File: rtl/lrb_half_merge.sv
module lrb_half_merge #(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] word_in,
    input  logic                sel_hi,
    input  logic [HALF_W-1:0]   new_half,
    output logic [HALF_W-1:0]   picked,
    output logic [2*HALF_W-1:0] merged
);
    always_comb begin
        picked = sel_hi ? word_in[2*HALF_W-1:HALF_W] : word_in[HALF_W-1:0];
        merged = sel_hi ? {new_half, word_in[HALF_W-1:0]}
                        : {word_in[2*HALF_W-1:HALF_W], new_half};
    end

endmodule

// File: rtl/lane_reg_bridge.sv
module lane_reg_bridge
    import lrb_pkg::*;
#(
    parameter int LANE_W    = 4,
    parameter int PAGE_W    = 4,
    parameter int REG_W     = 5,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 11,
    parameter int NUM_LANES = 14,
    parameter int NUM_PAGES = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [LANE_W-1:0]   req_lane,
    input  logic [PAGE_W-1:0]   req_page,
    input  logic [REG_W-1:0]    req_reg,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                done,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_error,
    output logic                mem_en,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [2*DATA_W-1:0] mem_wdata,
    input  logic [2*DATA_W-1:0] mem_rdata
);
    localparam int WORD_W = 2 * DATA_W;

    lrb_state_e state, state_nx;

    logic              wr_q;
    logic [LANE_W-1:0] lane_q;
    logic [PAGE_W-1:0] page_q;
    logic [REG_W-1:0]  reg_q;
    logic [DATA_W-1:0] wdata_q;
    logic [WORD_W-1:0] word_q;

    logic              map_in_range;
    logic              map_hole;
    logic [ADDR_W-1:0] map_addr;
    logic [WORD_W-1:0] merge_src;
    logic [DATA_W-1:0] half_pick;
    logic [WORD_W-1:0] half_merged;

    lrb_addr_map #(
        .LANE_W(LANE_W), .PAGE_W(PAGE_W), .REG_W(REG_W), .ADDR_W(ADDR_W),
        .NUM_LANES(NUM_LANES), .NUM_PAGES(NUM_PAGES)
    ) u_map (
        .lane(lane_q), .page(page_q), .reg_idx(reg_q),
        .in_range(map_in_range), .hole(map_hole), .word_addr(map_addr)
    );

    assign merge_src = (state == ST_RD_WAIT) ? mem_rdata : word_q;

    lrb_half_merge #(.HALF_W(DATA_W)) u_merge (
        .word_in(merge_src), .sel_hi(reg_q[0]), .new_half(wdata_q),
        .picked(half_pick), .merged(half_merged)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (req_valid) state_nx = ST_LOOKUP;
            ST_LOOKUP:   state_nx = (!map_in_range || map_hole) ? ST_RESP : ST_RD_ISSUE;
            ST_RD_ISSUE: state_nx = ST_RD_WAIT;
            ST_RD_WAIT:  state_nx = wr_q ? ST_WR_ISSUE : ST_RESP;
            ST_WR_ISSUE: state_nx = ST_RESP;
            ST_RESP:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q      <= 1'b0;
            lane_q    <= '0;
            page_q    <= '0;
            reg_q     <= '0;
            wdata_q   <= '0;
            word_q    <= '0;
            rsp_rdata <= '0;
            rsp_error <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        wr_q    <= req_write;
                        lane_q  <= req_lane;
                        page_q  <= req_page;
                        reg_q   <= req_reg;
                        wdata_q <= req_wdata;
                    end
                end
                ST_LOOKUP: begin
                    rsp_rdata <= '0;
                    rsp_error <= !map_in_range;
                end
                ST_RD_WAIT: begin
                    word_q <= mem_rdata;
                    if (!wr_q) rsp_rdata <= half_pick;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        unique case (state)
            ST_IDLE:     req_ready = 1'b1;
            ST_RD_ISSUE: mem_en    = 1'b1;
            ST_WR_ISSUE: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = half_merged;
            end
            ST_RESP:     done      = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr = map_addr;

    // R2: acceptance drops ready in the next cycle
    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2: done lasts one cycle
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a write strobe follows a read strobe two cycles earlier
    a_r7_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> $past(mem_en && !mem_we, 2));

    // R7: the write goes to the word that was read
    a_r7_same_word: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (mem_addr == $past(mem_addr, 2)));

    // R7: the neighbour half is the one returned by the bus
    a_r7_keep_neighbour: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (reg_q[0] ? (mem_wdata[DATA_W-1:0] == $past(mem_rdata[DATA_W-1:0]))
                                         : (mem_wdata[WORD_W-1:DATA_W] == $past(mem_rdata[WORD_W-1:DATA_W]))));

    // R9: an error response carries zero data and had no bus cycle before it
    a_r9_error_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rsp_error) |-> (rsp_rdata == '0 && !$past(mem_en) && !$past(mem_en, 2)));

endmodule

// File: tb/lane_reg_bridge_test.sv
module lane_reg_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [3:0]  req_lane = '0;
    logic [3:0]  req_page = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rsp_rdata;
    logic        rsp_error;
    logic        mem_en;
    logic        mem_we;
    logic [10:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    int n_checks = 0;
    int n_errors = 0;
    int n_rd = 0;
    int n_wr = 0;
    int cycles = 0;

    logic [31:0] mem [0:2047];

    always #10 clk = ~clk;

    lane_reg_bridge uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_lane(req_lane), .req_page(req_page),
        .req_reg(req_reg), .req_wdata(req_wdata), .done(done),
        .rsp_rdata(rsp_rdata), .rsp_error(rsp_error), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_word(int i);
        logic [15:0] lo;
        logic [15:0] hi;
        lo = 16'(i) ^ 16'h5A00;
        hi = 16'(i * 3) + 16'h1000;
        return {hi, lo};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) mem[i] <= init_word(i);
            mem_rdata <= '0;
        end else if (mem_en) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                n_wr <= n_wr + 1;
            end else begin
                mem_rdata <= mem[mem_addr];
                n_rd <= n_rd + 1;
            end
        end
    end

    // expected placement computed from the requirement formulas
    function automatic int exp_word(int lane, int page, int rg, output bit hole);
        int  b;
        bit  fast;
        hole = 1'b0;
        fast = (lane == 8) || (lane == 9) || (lane == 12) || (lane == 13);
        b = (lane / 2) * 1024 + (rg / 2) * 4 + page * 64;
        if (page < 4)        b += (lane % 2) * 256;
        else if (page < 8) begin
            if (lane == 8 || lane == 12) b += 256; else hole = 1'b1;
        end else if (page < 10) begin
            if (!fast) b += 256 + (lane % 2) * 128; else hole = 1'b1;
        end else begin
            if (fast) b += 128 + (lane % 2) * 128; else hole = 1'b1;
        end
        return b / 4;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one request; reports data, error, bus activity and handshake observations
    task automatic do_req(input bit wr, input int lane, input int page, input int rg,
                          input logic [15:0] wd, output logic [15:0] rd, output logic er,
                          output int rds, output int wrs, output int ready_busy,
                          output int done_after);
        int rd0, wr0;
        rd0 = n_rd; wr0 = n_wr;
        ready_busy = 0; rd = '0; er = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_lane = 4'(lane);
        req_page = 4'(page); req_reg = 5'(rg); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (done) begin
                rd = rsp_rdata; er = rsp_error;
                break;
            end
            if (req_ready) ready_busy++;
            @(negedge clk);
        end
        rds = n_rd - rd0; wrs = n_wr - wr0;
        @(negedge clk);
        done_after = int'(done);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(mem_en == 1'b0, "R1 mem_en", mem_en, 0);
    endtask

    task automatic t_handshake();
        logic [15:0] rd; logic er; int rds, wrs, rb, da;
        do_req(1'b0, 0, 0, 0, 16'h0, rd, er, rds, wrs, rb, da);
        chk(rb == 0, "R2 ready low while busy", rb, 0);
        chk(da == 0, "R2 done one cycle", da, 0);
        chk(req_ready == 1'b1, "R2 ready back", req_ready, 1);
        chk(rds == 1 && wrs == 0, "R6 single read", rds, 1);
        chk(rd == init_word(0)[15:0], "R6 even half", rd, init_word(0)[15:0]);
    endtask

    task automatic t_read(input int lane, input int page, input int rg, input string tag);
        logic [15:0] rd; logic er; int rds, wrs, rb, da, w; bit h;
        logic [15:0] exp;
        w = exp_word(lane, page, rg, h);
        exp = (rg % 2) ? init_word(w)[31:16] : init_word(w)[15:0];
        do_req(1'b0, lane, page, rg, 16'h0, rd, er, rds, wrs, rb, da);
        chk(rd == exp && !er, {tag, " read data"}, rd, exp);
        chk(rds == 1 && wrs == 0, {tag, " bus count"}, rds, 1);
    endtask

    task automatic t_hole(input int lane, input int page, input string tag);
        logic [15:0] rd; logic er; int rds, wrs, rb, da, w; bit h;
        w = exp_word(lane, page, 3, h);
        do_req(1'b0, lane, page, 3, 16'h0, rd, er, rds, wrs, rb, da);
        chk(rd == 16'h0 && !er && rds == 0 && wrs == 0, {tag, " hole read R8"}, {rd, 7'(rds)}, 0);
        do_req(1'b1, lane, page, 3, 16'hBEEF, rd, er, rds, wrs, rb, da);
        chk(!er && rds == 0 && wrs == 0, {tag, " hole write R8"}, rds + wrs, 0);
    endtask

    task automatic t_write_pair(input int lane, input int page, input int rg_even, input string tag);
        logic [15:0] rd; logic er; int rds, wrs, rb, da, w; bit h;
        logic [31:0] orig;
        w = exp_word(lane, page, rg_even, h);
        orig = init_word(w);
        do_req(1'b1, lane, page, rg_even, 16'hC0DE, rd, er, rds, wrs, rb, da);
        chk(rds == 1 && wrs == 1, {tag, " R7 rmw cycles"}, rds * 10 + wrs, 11);
        chk(mem[w] == {orig[31:16], 16'hC0DE}, {tag, " R7 even write"}, mem[w], {orig[31:16], 16'hC0DE});
        do_req(1'b1, lane, page, rg_even + 1, 16'h7E57, rd, er, rds, wrs, rb, da);
        chk(mem[w] == 32'h7E57_C0DE, {tag, " R7 odd write keeps even"}, mem[w], 32'h7E57_C0DE);
        do_req(1'b0, lane, page, rg_even, 16'h0, rd, er, rds, wrs, rb, da);
        chk(rd == 16'hC0DE, {tag, " R6 even readback"}, rd, 16'hC0DE);
        do_req(1'b0, lane, page, rg_even + 1, 16'h0, rd, er, rds, wrs, rb, da);
        chk(rd == 16'h7E57, {tag, " R6 odd readback"}, rd, 16'h7E57);
    endtask

    task automatic t_range(input int lane, input int page, input bit wr, input string tag);
        logic [15:0] rd; logic er; int rds, wrs, rb, da;
        do_req(wr, lane, page, 2, 16'hFFFF, rd, er, rds, wrs, rb, da);
        chk(er == 1'b1, {tag, " R9 error flag"}, er, 1);
        chk(rd == 16'h0 && rds == 0 && wrs == 0, {tag, " R9 quiet"}, rds + wrs, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake();
        t_read(3, 2, 7, "R3 lane3 page2");
        t_read(2, 0, 30, "R3 lane2 page0");
        t_read(8, 5, 4, "R4 lane8 page5");
        t_read(12, 7, 9, "R4 lane12 page7");
        t_read(5, 9, 10, "R5 slow lane5 page9");
        t_read(10, 8, 1, "R5 slow lane10 page8");
        t_read(13, 11, 31, "R5 fast lane13 page11");
        t_read(8, 10, 6, "R5 fast lane8 page10");
        t_hole(9, 5, "R4 lane9 page5");
        t_hole(0, 4, "R4 lane0 page4");
        t_hole(13, 8, "R5 lane13 page8");
        t_hole(4, 10, "R5 lane4 page10");
        t_write_pair(1, 3, 12, "lane1 page3");
        t_write_pair(9, 11, 20, "lane9 page11");
        t_range(14, 0, 1'b0, "lane14");
        t_range(2, 12, 1'b1, "page12");
        t_range(15, 15, 1'b0, "lane15 page15");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_checks = n_checks + 1;
            n_errors = n_errors + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule